// File: doc/BRIEF.md
# Histogram-Driven Tone Remap

The block sits in a raw video path carrying one 10-bit intensity per clock. While a frame streams through, it counts how often each of the 1024 input levels occurs. When the frame ends it uses the vertical blanking interval to build a 1024-entry remap table from that histogram, one bin per clock. The table is installed at the next frame start, and every pixel of that frame is looked up through it. A pixel therefore always sees a table built from the last fully counted frame.

A 2-bit policy input picks how the table is built. The four policies are:
- straight pass-through;
- cumulative-distribution equalization;
- linear stretch between a shadow and a highlight level measured from the histogram;
- linear stretch between two levels supplied on input pins.

The measured levels ignore a thin tail of about 0.5 % at each end of the histogram. A stretch whose highlight is not above its shadow falls back to pass-through. All divisions run on one shared shift-subtract divider during the build.

Top module: `tone_remap`

## Requirements
- R1: While rst_ni is low, pix_o and pix_valid_o are 0.
- R2: Until the first table has been installed, pix_o equals the pix_i of the previous cycle.
- R3: pix_valid_o is pix_valid_i delayed by one clock, and pix_o in that cycle is the remapped value. A pixel presented in the same cycle as sof_i already uses the table installed by that sof_i and is counted. Counted pixels run from the sof_i cycle through the eof_i cycle inclusive.
- R4: Policy 2'b01 (equalize) writes entry v = floor(C(v)*1023/N). C(v) is the number of counted pixels with level at most v, and N is the pixel count of the frame. Every table is non-decreasing in v.
- R5: Policy 2'b10 (auto stretch) measures its levels with threshold T = floor(N*41/8192). The shadow S is the lowest v with C(v) > T. The highlight H is the highest v with N - C(v-1) > T.
- R6: A stretch (policies 2'b10 and 2'b11) writes 0 for v <= S and 1023 for v >= H. Between those it writes floor((v-S)*1023/(H-S)). Policy 2'b11 takes S from fix_lo_i and H from fix_hi_i.
- R7: A stretch with H <= S, or any policy with N = 0, writes the identity table.
- R8: Policy 2'b00 writes the identity table.
- R9: Policy and fixed levels are sampled in the eof_i cycle; their values earlier in the frame have no effect.
- R10: A table is installed at the first sof_i after its build finishes. A frame whose sof_i arrives while a build is running uses the previously installed table, is not counted and triggers no build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 10 | Input pixel level |
| pix_valid_i | input | 1 | Input pixel qualifier |
| sof_i | input | 1 | Frame start pulse, may share a cycle with the first pixel |
| eof_i | input | 1 | Frame end pulse, may share a cycle with the last pixel |
| mode_i | input | 2 | Remap policy: 00 pass, 01 equalize, 10 auto stretch, 11 fixed stretch |
| fix_lo_i | input | 10 | Fixed shadow level for policy 11 |
| fix_hi_i | input | 10 | Fixed highlight level for policy 11 |
| pix_o | output | 10 | Remapped pixel |
| pix_valid_o | output | 1 | Output pixel qualifier |

## Verification
Three events can share one clock edge: a frame start that installs a new table, a lookup of the first pixel, and the first count of that pixel. The frame-end pulse can likewise share a cycle with the final counted pixel. Every frame in the bench drives sof_i together with its first valid pixel and eof_i together with its last. That first output is checked against the newly built model table, and the last pixel's weight is visible in the next table. A second collision comes from a frame start during an active build. It is provoked by sending a short frame a few cycles after a frame end, and it is judged twice: the frame's own pixels must still use the old table, and the table installed afterwards must show no trace of its pixels.

// File: rtl/tone_remap_pkg.sv
package tone_remap_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_EQUAL = 2'b01,
    MODE_AUTO  = 2'b10,
    MODE_FIXED = 2'b11
  } remap_mode_e;
endpackage

// File: rtl/tone_hist.sv
module tone_hist #(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [PIX_W-1:0] inc_bin_i,
  input  logic             tot_clr_i,
  input  logic [PIX_W-1:0] rd_bin_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic [CNT_W-1:0] total_o
);
  localparam int unsigned BINS = 1 << PIX_W;

  logic [CNT_W-1:0] bin_q [BINS];
  logic [CNT_W-1:0] total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BINS; i++) bin_q[i] <= '0;
    end else begin
      if (inc_i) bin_q[inc_bin_i] <= bin_q[inc_bin_i] + 1'b1;
      if (clr_i) bin_q[rd_bin_i] <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        total_q <= '0;
    else if (tot_clr_i) total_q <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i)     total_q <= total_q + 1'b1;
  end

  assign rd_cnt_o = bin_q[rd_bin_i];
  assign total_o  = total_q;

  // R10
  count_clear_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i && clr_i));
endmodule

// File: rtl/tone_div.sv
module tone_div #(
  parameter int unsigned NUM_W = 32,
  parameter int unsigned DEN_W = 22,
  parameter int unsigned Q_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [Q_W-1:0]   quo_o
);
  localparam int unsigned STEP_W = (Q_W > 1) ? $clog2(Q_W) : 1;

  logic [NUM_W-1:0]  rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [Q_W-1:0]    quo_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q, done_q;
  logic [NUM_W:0]    trial;
  logic              fits;

  // quotient bounded by Q_W bits, so only Q_W trial subtractions
  assign trial = (NUM_W+1)'(den_q) << step_q;
  assign fits  = {1'b0, rem_q} >= trial;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= num_i;
        den_q  <= den_i;
        quo_q  <= '0;
        step_q <= STEP_W'(Q_W-1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (fits) begin
          rem_q         <= rem_q - trial[NUM_W-1:0];
          quo_q[step_q] <= 1'b1;
        end
        if (step_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q - 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R4
  div_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && busy_q));
endmodule

// File: rtl/tone_lut.sv
module tone_lut #(
  parameter int unsigned PIX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PIX_W-1:0] wr_bin_i,
  input  logic [PIX_W-1:0] wr_val_i,
  input  logic             swap_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             valid_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             valid_o
);
  localparam int unsigned BINS = 1 << PIX_W;

  logic [PIX_W-1:0] bank_q [2][BINS];
  logic             active_q, live_q;
  logic             rd_bank, use_lut;

  // a frame start installs the new bank for the pixel in the same cycle
  assign rd_bank = swap_i ? ~active_q : active_q;
  assign use_lut = live_q | swap_i;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) bank_q[~active_q][wr_bin_i] <= wr_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      live_q   <= 1'b0;
      pix_o    <= '0;
      valid_o  <= 1'b0;
    end else begin
      if (swap_i) begin
        active_q <= ~active_q;
        live_q   <= 1'b1;
      end
      pix_o   <= use_lut ? bank_q[rd_bank][pix_i] : pix_i;
      valid_o <= valid_i;
    end
  end

  // R10
  write_swap_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && swap_i));
endmodule

// File: rtl/tone_build.sv
module tone_build
  import tone_remap_pkg::*;
#(
  parameter int unsigned PIX_W    = 10,
  parameter int unsigned CNT_W    = 22,
  parameter int unsigned CLIP_MUL = 41,
  parameter int unsigned CLIP_SHR = 13
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [1:0]             mode_i,
  input  logic [PIX_W-1:0]       fix_lo_i,
  input  logic [PIX_W-1:0]       fix_hi_i,
  input  logic [CNT_W-1:0]       total_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic                   swap_i,
  output logic [PIX_W-1:0]       rd_bin_o,
  output logic                   clr_o,
  output logic                   free_o,
  output logic                   ready_o,
  output logic                   wr_en_o,
  output logic [PIX_W-1:0]       wr_val_o,
  output logic                   div_start_o,
  output logic [CNT_W+PIX_W-1:0] div_num_o,
  output logic [CNT_W-1:0]       div_den_o,
  input  logic                   div_done_i,
  input  logic [PIX_W-1:0]       div_quo_i
);
  localparam int unsigned NUM_W = CNT_W + PIX_W;
  localparam int unsigned THR_W = CNT_W + 16;
  localparam logic [PIX_W-1:0] LAST_BIN = '1;
  localparam logic [NUM_W-1:0] MAXV_N   = NUM_W'((1 << PIX_W) - 1);

  typedef enum logic [2:0] {B_IDLE, B_SCAN, B_FILL, B_WAIT, B_DONE} state_e;

  state_e           state_q;
  remap_mode_e      mode_q;
  logic [PIX_W-1:0] bin_q, lo_q, hi_q, sh_q, hl_q;
  logic             sh_found_q;
  logic [CNT_W-1:0] cdf_q;

  logic [THR_W-1:0] thr_prod, thr_c;
  logic [CNT_W-1:0] cdf_nxt, tail;
  logic             above_lo, tail_hi;
  logic [PIX_W-1:0] lo_eff, hi_eff, dir_val;
  logic             stretch, ident, need_div, advance;
  logic [NUM_W-1:0] num_c;
  logic [CNT_W-1:0] den_c;

  assign thr_prod = THR_W'(total_i) * THR_W'(CLIP_MUL);
  assign thr_c    = thr_prod >> CLIP_SHR;
  assign cdf_nxt  = cdf_q + cnt_i;
  assign tail     = total_i - cdf_q;
  assign above_lo = THR_W'(cdf_nxt) > thr_c;
  assign tail_hi  = THR_W'(tail) > thr_c;

  assign lo_eff  = (mode_q == MODE_AUTO) ? sh_q : lo_q;
  assign hi_eff  = (mode_q == MODE_AUTO) ? hl_q : hi_q;
  assign stretch = mode_q[1];
  assign ident   = (mode_q == MODE_PASS) || (total_i == '0) || (stretch && (hi_eff <= lo_eff));

  always_comb begin
    dir_val  = '0;
    need_div = 1'b0;
    num_c    = '0;
    den_c    = '0;
    if (ident) begin
      dir_val = bin_q;
    end else if (!stretch) begin
      if (cdf_nxt == '0)          dir_val = '0;
      else if (cdf_nxt == total_i) dir_val = LAST_BIN;
      else begin
        need_div = 1'b1;
        num_c    = NUM_W'(cdf_nxt) * MAXV_N;
        den_c    = total_i;
      end
    end else begin
      if (bin_q <= lo_eff)      dir_val = '0;
      else if (bin_q >= hi_eff) dir_val = LAST_BIN;
      else begin
        need_div = 1'b1;
        num_c    = NUM_W'(bin_q - lo_eff) * MAXV_N;
        den_c    = CNT_W'(hi_eff - lo_eff);
      end
    end
  end

  assign wr_en_o     = ((state_q == B_FILL) && !need_div) || ((state_q == B_WAIT) && div_done_i);
  assign wr_val_o    = (state_q == B_WAIT) ? div_quo_i : dir_val;
  assign advance     = wr_en_o;
  assign clr_o       = wr_en_o;
  assign rd_bin_o    = bin_q;
  assign div_start_o = (state_q == B_FILL) && need_div;
  assign div_num_o   = num_c;
  assign div_den_o   = den_c;
  assign free_o      = (state_q == B_IDLE) || (state_q == B_DONE);
  assign ready_o     = (state_q == B_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= B_IDLE;
      mode_q     <= MODE_PASS;
      bin_q      <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      sh_q       <= '0;
      hl_q       <= '0;
      sh_found_q <= 1'b0;
      cdf_q      <= '0;
    end else begin
      unique case (state_q)
        B_IDLE: if (start_i) begin
          mode_q     <= remap_mode_e'(mode_i);
          lo_q       <= fix_lo_i;
          hi_q       <= fix_hi_i;
          bin_q      <= '0;
          cdf_q      <= '0;
          sh_q       <= '0;
          hl_q       <= '0;
          sh_found_q <= 1'b0;
          state_q    <= B_SCAN;
        end
        B_SCAN: begin
          if (!sh_found_q && above_lo) begin
            sh_q       <= bin_q;
            sh_found_q <= 1'b1;
          end
          if (tail_hi) hl_q <= bin_q;
          if (bin_q == LAST_BIN) begin
            bin_q   <= '0;
            cdf_q   <= '0;
            state_q <= B_FILL;
          end else begin
            bin_q <= bin_q + 1'b1;
            cdf_q <= cdf_nxt;
          end
        end
        B_FILL, B_WAIT: begin
          if (state_q == B_FILL && need_div) state_q <= B_WAIT;
          if (advance) begin
            cdf_q <= cdf_nxt;
            if (bin_q == LAST_BIN) state_q <= B_DONE;
            else begin
              bin_q   <= bin_q + 1'b1;
              state_q <= B_FILL;
            end
          end
        end
        B_DONE: if (swap_i) state_q <= B_IDLE;
        default: state_q <= B_IDLE;
      endcase
    end
  end

  // checker state: last entry written in this build
  logic [PIX_W-1:0] last_val_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_val_q <= '0;
    else if (wr_en_o) last_val_q <= wr_val_o;
  end

  // R4
  table_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && bin_q != '0) |-> wr_val_o >= last_val_q);

  // R10
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> state_q == B_IDLE);
endmodule

// File: rtl/tone_remap.sv
module tone_remap #(
  parameter int unsigned PIX_W    = 10,
  parameter int unsigned CNT_W    = 22,
  parameter int unsigned CLIP_MUL = 41,
  parameter int unsigned CLIP_SHR = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [1:0]       mode_i,
  input  logic [PIX_W-1:0] fix_lo_i,
  input  logic [PIX_W-1:0] fix_hi_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_valid_o
);
  localparam int unsigned NUM_W = CNT_W + PIX_W;

  logic             counting_q, free, ready, start_cnt, count_now, build_go, swap;
  logic [PIX_W-1:0] rd_bin, wr_val, quo;
  logic [CNT_W-1:0] rd_cnt, total, den;
  logic [NUM_W-1:0] num;
  logic             clr, wr_en, div_start, div_done;

  assign start_cnt = sof_i & free;
  assign count_now = pix_valid_i & (counting_q | start_cnt);
  assign build_go  = eof_i & counting_q;
  assign swap      = sof_i & ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        counting_q <= 1'b0;
    else if (eof_i)     counting_q <= 1'b0;
    else if (start_cnt) counting_q <= 1'b1;
  end

  tone_hist #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_hist (
    .clk_i, .rst_ni,
    .inc_i(count_now), .inc_bin_i(pix_i), .tot_clr_i(start_cnt),
    .rd_bin_i(rd_bin), .clr_i(clr), .rd_cnt_o(rd_cnt), .total_o(total)
  );

  tone_build #(.PIX_W(PIX_W), .CNT_W(CNT_W), .CLIP_MUL(CLIP_MUL), .CLIP_SHR(CLIP_SHR)) u_build (
    .clk_i, .rst_ni,
    .start_i(build_go), .mode_i, .fix_lo_i, .fix_hi_i,
    .total_i(total), .cnt_i(rd_cnt), .swap_i(swap),
    .rd_bin_o(rd_bin), .clr_o(clr), .free_o(free), .ready_o(ready),
    .wr_en_o(wr_en), .wr_val_o(wr_val),
    .div_start_o(div_start), .div_num_o(num), .div_den_o(den),
    .div_done_i(div_done), .div_quo_i(quo)
  );

  tone_div #(.NUM_W(NUM_W), .DEN_W(CNT_W), .Q_W(PIX_W)) u_div (
    .clk_i, .rst_ni,
    .start_i(div_start), .num_i(num), .den_i(den),
    .done_o(div_done), .quo_o(quo)
  );

  tone_lut #(.PIX_W(PIX_W)) u_lut (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_bin_i(rd_bin), .wr_val_i(wr_val), .swap_i(swap),
    .pix_i, .valid_i(pix_valid_i), .pix_o, .valid_o(pix_valid_o)
  );
endmodule

// File: tb/tone_remap_test.sv
module tone_remap_test;
  localparam int NB = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] pix = '0, lo = '0, hi = '0;
  logic       vld = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [1:0] mode = '0;
  logic [9:0] pix_o;
  logic       vld_o;

  always #5 clk = ~clk;

  tone_remap uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .pix_valid_i(vld),
    .sof_i(sof), .eof_i(eof), .mode_i(mode), .fix_lo_i(lo), .fix_hi_i(hi),
    .pix_o(pix_o), .pix_valid_o(vld_o)
  );

  int n_chk = 0, n_fail = 0;
  int px_buf[256];
  int act_lut[NB], nxt_lut[NB];
  bit act_live = 0, nxt_ok = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void build_model(input int n, input int md, input int flo, input int fhi);
    longint h[NB];
    longint cdf[NB];
    longint tot, thr, run;
    int s, hh;
    bit ident;
    for (int v = 0; v < NB; v++) h[v] = 0;
    for (int i = 0; i < n; i++) h[px_buf[i]]++;
    tot = n;
    run = 0;
    for (int v = 0; v < NB; v++) begin run += h[v]; cdf[v] = run; end
    thr = (tot * 41) >> 13;
    s = flo; hh = fhi;
    if (md == 2) begin
      s = -1; hh = 0;
      for (int v = 0; v < NB; v++) begin
        if (s < 0 && cdf[v] > thr) s = v;
        if (tot - ((v == 0) ? 0 : cdf[v-1]) > thr) hh = v;
      end
      if (s < 0) s = 0;
    end
    ident = (md == 0) || (tot == 0) || (md >= 2 && hh <= s);
    for (int v = 0; v < NB; v++) begin
      if (ident) nxt_lut[v] = v;
      else if (md == 1) nxt_lut[v] = int'((cdf[v] * 1023) / tot);
      else if (v <= s) nxt_lut[v] = 0;
      else if (v >= hh) nxt_lut[v] = 1023;
      else nxt_lut[v] = ((v - s) * 1023) / (hh - s);
    end
  endfunction

  // sof shares a cycle with the first pixel, eof with the last; policy switches at n/2
  task automatic send_frame(input int n, input int md_a, input int md_b, input int flo,
                            input int fhi, input bit counted, input string req);
    int exp;
    if (nxt_ok) begin
      act_lut  = nxt_lut;
      act_live = 1;
      nxt_ok   = 0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix  = 10'(px_buf[i]);
      vld  = 1'b1;
      sof  = (i == 0);
      eof  = (i == n - 1);
      mode = 2'((i < n / 2) ? md_a : md_b);
      lo   = 10'(flo);
      hi   = 10'(fhi);
      @(posedge clk); #1;
      exp = act_live ? act_lut[px_buf[i]] : px_buf[i];
      check(vld_o === 1'b1 && int'(pix_o) == exp, req, int'(pix_o), exp);
    end
    @(negedge clk);
    vld = 1'b0; sof = 1'b0; eof = 1'b0;
    @(posedge clk); #1;
    check(vld_o === 1'b0, "R3 valid drop", int'(vld_o), 0);
    if (counted) build_model(n, md_b, flo, fhi);
  endtask

  task automatic wait_build();
    repeat (15000) @(posedge clk);
    nxt_ok = 1;
  endtask

  task automatic t_reset();
    #1;
    check(pix_o == '0, "R1 pix_o", int'(pix_o), 0);
    check(vld_o == 1'b0, "R1 valid", int'(vld_o), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_passthrough();
    for (int i = 0; i < 128; i++) px_buf[i] = (i * i * 7 + 11) % NB;
    send_frame(128, 1, 1, 0, 0, 1, "R2 before first table");
    wait_build();
  endtask

  task automatic t_equalize();
    px_buf[0] = 5;
    for (int i = 1; i < 199; i++) px_buf[i] = 100 + (i * 3) % 500;
    px_buf[199] = 1000;
    // policy 11 early in the frame must not matter: eof sees 10
    send_frame(200, 3, 2, 0, 0, 1, "R4 R3 equalize");
    wait_build();
  endtask

  task automatic t_auto();
    for (int i = 0; i < 160; i++) px_buf[i] = (i * 1023) / 159;
    send_frame(160, 3, 3, 200, 800, 1, "R5 R6 R9 auto stretch");
    wait_build();
  endtask

  task automatic t_fixed();
    for (int i = 0; i < 160; i++) px_buf[i] = (i * 1023) / 159;
    send_frame(160, 1, 1, 0, 0, 1, "R6 fixed stretch");
  endtask

  task automatic t_overlap();
    repeat (20) @(posedge clk);
    for (int i = 0; i < 16; i++) px_buf[i] = 1023;
    send_frame(16, 3, 3, 600, 600, 0, "R10 frame during build");
    wait_build();
    for (int i = 0; i < 128; i++) px_buf[i] = (i * 37) % NB;
    send_frame(128, 0, 0, 0, 0, 1, "R10 table from last counted frame");
    wait_build();
  endtask

  task automatic t_mode_pass();
    for (int i = 0; i < 64; i++) px_buf[i] = (i * 91 + 3) % NB;
    send_frame(64, 3, 3, 600, 600, 1, "R8 pass policy");
    wait_build();
  endtask

  task automatic t_fallback();
    for (int i = 0; i < 64; i++) px_buf[i] = (i * 53) % NB;
    send_frame(64, 0, 0, 0, 0, 0, "R7 degenerate stretch");
  endtask

  initial begin
    t_reset();
    repeat (2) @(posedge clk);
    t_passthrough();
    t_equalize();
    t_auto();
    t_fixed();
    t_overlap();
    t_mode_pass();
    t_fallback();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule